// File: doc/BRIEF.md
# Chip-Select Gated Serial Result Port

This block is the serial output stage that sits beside a sampling converter's sequencer. It holds the most recent conversion result and delivers it, most significant bit first, on a single data line whose pad driver has a separate enable. An external host supplies the serial clock. The convert-start line also acts as the chip select: its rising edge arms the port and clears the bit counter. After ten serial clocks the port releases the line and ignores any further clocks until the convert-start line rises again. The serial clock may run freely or be gated between bits.

The sequencer loads a new result through a request/acknowledge handshake. The port grants a load only while it is not busy, which means not between an arming edge and the end of the tenth bit. A read that starts before the current conversion has been written therefore returns the previous result. Because the port has no tie to the converter core's power state, reads still work while the core is powered down. All external lines are synchronised into the system clock, so every reaction is delayed by a few system-clock cycles after the external edge.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `sdo_oe_o`, `busy_o` and `sdo_o` are 0. `load_ack_o` is 0 while no load is requested.
- R2: A rising edge on `conv_start_i` sets `busy_o` to 1 and clears the bit counter. `sdo_oe_o` stays 0 until the next serial-clock rising edge.
- R3: Each `sclk_i` rising edge after arming drives the next result bit on `sdo_o`, starting with bit 9 and ending with bit 0. The first such edge sets `sdo_oe_o` to 1.
- R4: On the falling edge of the tenth `sclk_i` pulse, `sdo_oe_o` and `busy_o` both return to 0.
- R5: `sclk_i` edges that arrive while the port is not armed leave `sdo_oe_o` at 0 and `sdo_o` unchanged. This covers edges after the tenth bit and edges before any arming.
- R6: `load_ack_o` is 1 only when `load_req_i` is 1 and `busy_o` is 0. An acknowledged `load_data_i` becomes the word shifted out by the next read.
- R7: A load requested while the port is busy is held off until the transfer completes, so that read returns the previous result. The pending load is acknowledged once `busy_o` falls.
- R8: A `conv_start_i` rising edge in the middle of a transfer restarts the transfer from bit 9 of the held result.
- R9: The transfer result does not depend on how long `sclk_i` idles between bits, whether the gaps are short (continuous) or long (gated).
- R10: A falling edge of `conv_start_i` during a transfer has no effect on the bits shifted out or on the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Convert-start line, rising edge arms the port |
| sclk_i | input | 1 | External serial clock |
| load_req_i | input | 1 | Sequencer request to store a new result |
| load_data_i | input | 10 | Result word to store |
| load_ack_o | output | 1 | Load granted this cycle |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Pad driver enable for the serial data line |
| busy_o | output | 1 | Port armed, transfer not yet complete |

## Verification
The hardest case to produce from the ports is a load that collides with a transfer in flight. The sequencer must raise its request after arming and keep it up across all ten serial clocks, and the bench must show both that the old word comes out and that the new word goes in as soon as the port frees up. The bench arms the port, raises the request with a distinct pattern, and reads with the request still held. It then confirms the acknowledge fires once the port is idle and that the following read returns the new pattern. Re-arming after four bits and dropping the convert-start line mid-read are reached with directed sequences.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned RES_W = 10;
  localparam int unsigned SYNC_STAGES = 2;
  // synchronised line positions
  localparam int unsigned LN_SCLK = 0;
  localparam int unsigned LN_CONV = 1;
  localparam int unsigned N_LINES = 2;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], async_i[b]};
    end
    assign cur_o[b]  = pipe_q[STAGES-1];
    assign prev_o[b] = pipe_q[STAGES];
  end
endmodule

// File: rtl/srp_hold.sv
module srp_hold #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             arm_i,
  input  logic             load_req_i,
  input  logic [RES_W-1:0] load_data_i,
  output logic             load_ack_o,
  output logic [RES_W-1:0] hold_o
);
  logic [RES_W-1:0] hold_q;

  // no load while armed or while arming this cycle
  assign load_ack_o = load_req_i & ~busy_i & ~arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (load_ack_o) hold_q <= load_data_i;
  end

  assign hold_o = hold_q;

  assert_ack_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ack_o |-> (!busy_i && load_req_i));
endmodule

// File: rtl/srp_shift_ctrl.sv
module srp_shift_ctrl #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic [RES_W-1:0] hold_i,
  output logic             busy_o,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int unsigned CNT_W = $clog2(RES_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

  logic             armed_q;
  logic             oe_q;
  logic             dout_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] shift_q;
  logic             done;

  assign done = armed_q & sclk_fall_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      oe_q    <= 1'b0;
      cnt_q   <= '0;
      shift_q <= hold_i;
    end else if (armed_q && sclk_rise_i && cnt_q != LAST) begin
      oe_q    <= 1'b1;
      dout_q  <= shift_q[RES_W-1];
      shift_q <= {shift_q[RES_W-2:0], 1'b0};
      cnt_q   <= cnt_q + 1'b1;
    end else if (done) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end
  end

  assign busy_o   = armed_q;
  assign sdo_o    = dout_q;
  assign sdo_oe_o = oe_q;

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_arm_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_q && cnt_q == '0 && !oe_q));
  assert_oe_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(sclk_rise_i));
  assert_oe_drops_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !arm_i |=> (!oe_q && !armed_q));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import srp_pkg::*;
#(
  parameter int unsigned DATA_W = RES_W,
  parameter int unsigned SYNC_N = SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              sclk_i,
  input  logic              load_req_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              load_ack_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o
);
  logic [N_LINES-1:0] lines, cur, prev;
  logic               conv_rise, sclk_rise, sclk_fall;
  logic [DATA_W-1:0]  hold;

  assign lines[LN_SCLK] = sclk_i;
  assign lines[LN_CONV] = conv_start_i;

  srp_sync #(.WIDTH(N_LINES), .STAGES(SYNC_N)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (lines),
    .cur_o   (cur),
    .prev_o  (prev)
  );

  assign conv_rise = cur[LN_CONV] & ~prev[LN_CONV];
  assign sclk_rise = cur[LN_SCLK] & ~prev[LN_SCLK];
  assign sclk_fall = ~cur[LN_SCLK] & prev[LN_SCLK];

  srp_hold #(.RES_W(DATA_W)) i_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_o),
    .arm_i       (conv_rise),
    .load_req_i  (load_req_i),
    .load_data_i (load_data_i),
    .load_ack_o  (load_ack_o),
    .hold_o      (hold)
  );

  srp_shift_ctrl #(.RES_W(DATA_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (conv_rise),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .hold_i      (hold),
    .busy_o      (busy_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  assert_oe_needs_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> busy_o);
  assert_hold_stable_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(hold));
endmodule

// File: tb/test_serial_result_port.sv
module test_serial_result_port;
  localparam int W = 10;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic sclk = 1'b0;
  logic req = 1'b0;
  logic [W-1:0] din = '0;
  logic ack, sdo, oe, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_result_port i_serial_result_port (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(conv), .sclk_i(sclk),
    .load_req_i(req), .load_data_i(din), .load_ack_o(ack),
    .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy)
  );

  // bit 10: gated clock with long idle gaps; bits 9:0 result word
  localparam logic [W:0] VECS [8] = '{
    11'h2A5, 11'h0FF, 11'h600, 11'h401, 11'h3FF, 11'h000, 11'h555, 11'h1C3
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); conv = 1'b0; wait_neg(SETTLE);
    conv = 1'b1; wait_neg(SETTLE);
  endtask

  task automatic pulse(input int gap);
    @(negedge clk); sclk = 1'b1; wait_neg(SETTLE);
    sclk = 1'b0; wait_neg(SETTLE + gap);
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk); req = 1'b1; din = v;
    for (int i = 0; i < 200 && !ack; i++) @(negedge clk);
    check(ack === 1'b1, "R6 load ack", int'(ack), 1);
    @(negedge clk); req = 1'b0;
  endtask

  // read n bits; returns word and whether oe stayed high while driving
  task automatic read_bits(input int n, input int gap, output logic [W-1:0] word,
                           output bit oe_ok);
    word = '0; oe_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1; wait_neg(SETTLE);
      word = {word[W-2:0], sdo};
      if (oe !== 1'b1) oe_ok = 1'b0;
      if (i == n - 1 && n == W) begin
        @(negedge clk); sclk = 1'b0; wait_neg(SETTLE + gap);
      end else begin
        @(negedge clk); sclk = 1'b0; wait_neg(SETTLE);
        if (oe !== 1'b1) oe_ok = 1'b0;
        wait_neg(gap);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic         last;
    bit           ok;

    wait_neg(3);
    check(oe === 1'b0 && busy === 1'b0 && sdo === 1'b0 && ack === 1'b0,
          "R1 reset state", {oe, busy, sdo, ack}, 0);
    rst_n = 1'b1;
    wait_neg(3);
    check(oe === 1'b0 && busy === 1'b0, "R1 after release", {oe, busy}, 0);

    // R5: clocks before any arming are ignored
    pulse(0); pulse(0);
    check(oe === 1'b0 && sdo === 1'b0, "R5 unarmed clocks", {oe, sdo}, 0);

    // table walk: R3 order, R4 end of frame, R9 gap independence
    foreach (VECS[k]) begin
      load(VECS[k][W-1:0]);
      arm();
      check(busy === 1'b1 && oe === 1'b0, "R2 armed idle line", {busy, oe}, 2);
      read_bits(W, VECS[k][W] ? 40 : 0, w, ok);
      check(w === VECS[k][W-1:0] && ok, VECS[k][W] ? "R9 gated word" : "R3 word",
            int'(w), int'(VECS[k][W-1:0]));
      check(oe === 1'b0 && busy === 1'b0, "R4 release after tenth", {oe, busy}, 0);
    end

    // R5: extra clocks after the tenth bit
    last = sdo;
    pulse(0); pulse(0); pulse(0);
    check(oe === 1'b0 && sdo === last && busy === 1'b0, "R5 extra clocks",
          {oe, sdo, busy}, {1'b0, last, 1'b0});

    // R6/R7: load held off during a transfer
    load(10'h13C);
    arm();
    @(negedge clk); req = 1'b1; din = 10'h2C3;
    wait_neg(2);
    check(ack === 1'b0, "R6 no ack while busy", int'(ack), 0);
    read_bits(W, 0, w, ok);
    check(w === 10'h13C, "R7 previous result shifted", int'(w), 10'h13C);
    check(ack === 1'b1, "R7 pending load acked", int'(ack), 1);
    @(negedge clk); req = 1'b0;
    arm();
    read_bits(W, 0, w, ok);
    check(w === 10'h2C3, "R6 new word read", int'(w), 10'h2C3);

    // R8: re-arm mid transfer restarts at bit 9
    load(10'h3A6);
    arm();
    read_bits(4, 0, w, ok);
    check(w[3:0] === 4'hE, "R8 partial bits", int'(w[3:0]), 4'hE);
    arm();
    check(busy === 1'b1 && oe === 1'b0, "R8 rearm clears", {busy, oe}, 2);
    read_bits(W, 0, w, ok);
    check(w === 10'h3A6 && ok, "R8 full word after rearm", int'(w), 10'h3A6);

    // R10: convert-start falling during a read has no effect
    load(10'h259);
    arm();
    read_bits(3, 0, w, ok);
    @(negedge clk); conv = 1'b0; wait_neg(SETTLE);
    check(busy === 1'b1 && oe === 1'b1, "R10 fall keeps frame", {busy, oe}, 3);
    begin
      logic [W-1:0] rest;
      read_bits(7, 0, rest, ok);
      w = {w[2:0], rest[6:0]};
      pulse(0);
    end
    check(w === 10'h259, "R10 word intact", int'(w), 10'h259);
    check(oe === 1'b0 && busy === 1'b0, "R10 ends on tenth", {oe, busy}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule